// File: doc/BRIEF.md
# Warp Issue Scheduler with Per-Warp Scoreboard

This block chooses, every clock, at most one resident warp of a processor sub-partition and sends that warp's next instruction to a 16-lane integer pipe. Each warp slot offers its next instruction on its own valid/ready channel. The instruction names one destination register and two source registers. A warp may issue only when two conditions hold. None of its operands may still be waiting on a result from an earlier instruction of the same warp. The pipe must also be free to take a new instruction. Because a 32-thread warp needs two passes through a 16-lane pipe, the pipe accepts work at most every other cycle. The scheduler does not pay any cost when it moves from one warp to another, so a second warp can use the cycles that the first warp spends stalled.

A warp keeps its slot index for its whole life. Selection looks only at warp slots and has no notion of thread blocks. Three free-running counters report elapsed cycles, cycles with an issue, and cycles in which the pipe was occupied. Software can divide these counters to get issue and pipe utilisation.

Top module: `warp_issue_sched`

## Requirements
- R1: After a warp issues an instruction that writes register d, a later instruction of the same warp that reads d, or writes d again, issues no earlier than DEP_LAT cycles after the producer. DEP_LAT is a parameter from 4 to 16 and defaults to 4.
- R2: At most one instruction issues per cycle. issue_valid is a one-cycle pulse, and in that cycle issue_warp, issue_dst, issue_src0 and issue_src1 carry the slot index and the fields of the instruction taken.
- R3: One issue occupies the pipe for WARP_THREADS/PIPE_LANES cycles, which is 2 at the defaults. No instruction issues in the cycle that follows an issue.
- R4: A warp with no pending dependency is held as throttled while the pipe is busy. It issues in the first cycle in which the pipe is free.
- R5: Consecutive issues from different warps are spaced only by the pipe occupancy. Switching warps adds no extra cycle.
- R6: One warp running the chain r0=r1+r2, r4=r0+r3, r8=r0+r4 with DEP_LAT=4 issues in cycles 0, 4 and 8. Over 12 cycles the counters show 3 issue cycles and 6 pipe-busy cycles.
- R7: Two warps each running that chain issue alternately in cycles 0, 2, 4, 6, 8 and 10. Over 12 cycles the counters show 6 issue cycles and 12 pipe-busy cycles.
- R8: When several warps are eligible, the grant goes to the first eligible slot after the slot that issued last, in ascending order with wrap-around. After reset, slot 0 is first in line.
- R9: A slot whose inst_valid is low is never granted, and its inst_ready stays low.
- R10: The scoreboard is per warp. A register pending in one warp never delays another warp.
- R11: cnt_cycles counts every clock, cnt_issue counts clocks with an issue, and cnt_pipe_busy counts clocks in which the pipe is occupied. A synchronous reset clears all three counters, every scoreboard entry, the pipe throttle and the round-robin position, so an instruction that was waiting before reset can issue in the first cycle after it.
- R12: Each slot's channel follows valid/ready rules. inst_ready[w] is high only in the cycle its instruction is taken, and it is then the only ready bit that is high. A source must hold its fields stable while valid is high and ready is low, because this back-pressure lasts as long as the slot is stalled. Slot w's fields occupy bits [w*5 +: 5] of inst_dst, inst_src0 and inst_src1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inst_valid | input | NUM_WARPS | Slot w offers an instruction |
| inst_ready | output | NUM_WARPS | Slot w's instruction is taken this cycle |
| inst_dst | input | NUM_WARPS*5 | Destination register index for each slot |
| inst_src0 | input | NUM_WARPS*5 | First source register index for each slot |
| inst_src1 | input | NUM_WARPS*5 | Second source register index for each slot |
| issue_valid | output | 1 | An instruction goes to the pipe this cycle |
| issue_warp | output | WARP_IDX_W | Slot that issued |
| issue_dst | output | 5 | Destination of the issued instruction |
| issue_src0 | output | 5 | First source of the issued instruction |
| issue_src1 | output | 5 | Second source of the issued instruction |
| cnt_cycles | output | CNT_W | Elapsed cycles since reset |
| cnt_issue | output | CNT_W | Cycles with an issue |
| cnt_pipe_busy | output | CNT_W | Cycles with the pipe occupied |

## Verification
The bench builds the scheduler twice. The first instance uses four slots and the default dependent latency of 4, which gives the single-chain and two-chain utilisation figures, the throttled hand-over between warps, the four-way round-robin rotation and a reset that lands in the middle of a dependency wait. The second instance uses a latency of 16 and the same chain. It reaches the upper end of the latency range, where the dependent adds must land in cycles 0, 16 and 32.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int REG_IDX_W = 5;
  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     valid;
    reg_idx_t dst;
    reg_idx_t src0;
    reg_idx_t src1;
  } wis_instr_t;
endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard
  import wis_pkg::*;
#(
  parameter int DEP_LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  wis_instr_t instr,
  input  logic       issue_en,
  output logic       dep_clear
);
  localparam int NUM_REGS = 1 << REG_IDX_W;
  localparam int LAT_W    = $clog2(DEP_LAT + 1);

  logic [LAT_W-1:0] remain [NUM_REGS];

  // Per-register countdown, loaded on issue of a writer and drained to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) remain[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (issue_en && instr.dst == reg_idx_t'(r))
          remain[r] <= LAT_W'(DEP_LAT - 1);
        else if (remain[r] != '0)
          remain[r] <= remain[r] - 1'b1;
      end
    end
  end

  always_comb begin
    dep_clear = instr.valid
             && remain[instr.src0] == '0
             && remain[instr.src1] == '0
             && remain[instr.dst]  == '0;
  end

  // R1: an instruction touching the register just written cannot be clear next cycle
  assert_dep_block_R1: assert property (@(posedge clk) disable iff (rst)
    issue_en |=> !dep_clear
                 || (instr.src0 != $past(instr.dst) && instr.src1 != $past(instr.dst)
                     && instr.dst != $past(instr.dst)));
endmodule

// File: rtl/wis_pipe_throttle.sv
module wis_pipe_throttle #(
  parameter int OCC_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  output logic pipe_free,
  output logic pipe_active
);
  localparam int OCC_W = $clog2(OCC_CYCLES + 1);

  logic [OCC_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst)
      hold <= '0;
    else if (issue)
      hold <= OCC_W'(OCC_CYCLES - 1);
    else if (hold != '0)
      hold <= hold - 1'b1;
  end

  assign pipe_free   = (hold == '0);
  assign pipe_active = issue || !pipe_free;

  // R4: the arbiter never hands work to a pipe that is still occupied
  assert_no_issue_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !(issue && !pipe_free));
endmodule

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_any
);
  logic [IDX_W-1:0] last;

  // Search starts one past the last winner and wraps around.
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    grant_any = 1'b0;
    for (int off = 1; off <= N; off++) begin
      if (!grant_any && req[(int'(last) + off) % N]) begin
        grant_any                       = 1'b1;
        grant[(int'(last) + off) % N]   = 1'b1;
        grant_idx                       = IDX_W'((int'(last) + off) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      last <= IDX_W'(N - 1);
    else if (grant_any)
      last <= grant_idx;
  end

  // R2: never more than one winner
  assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/wis_util_counters.sv
module wis_util_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             pipe_active,
  output logic [CNT_W-1:0] cnt_cycles,
  output logic [CNT_W-1:0] cnt_issue,
  output logic [CNT_W-1:0] cnt_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_cycles <= '0;
      cnt_issue  <= '0;
      cnt_busy   <= '0;
    end else begin
      cnt_cycles <= cnt_cycles + 1'b1;
      if (issue)       cnt_issue <= cnt_issue + 1'b1;
      if (pipe_active) cnt_busy  <= cnt_busy + 1'b1;
    end
  end

  // R11: issue cycles are a subset of busy cycles, which are a subset of all cycles
  assert_count_order_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_issue <= cnt_busy && cnt_busy <= cnt_cycles);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS    = 4,
  parameter int DEP_LAT      = 4,
  parameter int WARP_THREADS = 32,
  parameter int PIPE_LANES   = 16,
  parameter int CNT_W        = 32,
  parameter int WARP_IDX_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WARPS-1:0]           inst_valid,
  output logic [NUM_WARPS-1:0]           inst_ready,
  input  logic [NUM_WARPS*REG_IDX_W-1:0] inst_dst,
  input  logic [NUM_WARPS*REG_IDX_W-1:0] inst_src0,
  input  logic [NUM_WARPS*REG_IDX_W-1:0] inst_src1,
  output logic                           issue_valid,
  output logic [WARP_IDX_W-1:0]          issue_warp,
  output logic [REG_IDX_W-1:0]           issue_dst,
  output logic [REG_IDX_W-1:0]           issue_src0,
  output logic [REG_IDX_W-1:0]           issue_src1,
  output logic [CNT_W-1:0]               cnt_cycles,
  output logic [CNT_W-1:0]               cnt_issue,
  output logic [CNT_W-1:0]               cnt_pipe_busy
);
  localparam int OCC_CYCLES = (WARP_THREADS + PIPE_LANES - 1) / PIPE_LANES;

  wis_instr_t             slot_instr [NUM_WARPS];
  logic [NUM_WARPS-1:0]   dep_clear;
  logic [NUM_WARPS-1:0]   req;
  logic [NUM_WARPS-1:0]   grant;
  logic [WARP_IDX_W-1:0]  grant_idx;
  logic                   grant_any;
  logic                   pipe_free;
  logic                   pipe_active;

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      assign slot_instr[w] = '{valid: inst_valid[w],
                               dst:   inst_dst [w*REG_IDX_W +: REG_IDX_W],
                               src0:  inst_src0[w*REG_IDX_W +: REG_IDX_W],
                               src1:  inst_src1[w*REG_IDX_W +: REG_IDX_W]};

      wis_scoreboard #(.DEP_LAT(DEP_LAT)) u_sb (
        .clk       (clk),
        .rst       (rst),
        .instr     (slot_instr[w]),
        .issue_en  (grant[w]),
        .dep_clear (dep_clear[w])
      );
    end
  endgenerate

  // Eligible: dependencies settled and pipe accepting work.
  assign req = dep_clear & {NUM_WARPS{pipe_free}};

  wis_rr_arbiter #(.N(NUM_WARPS), .IDX_W(WARP_IDX_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  wis_pipe_throttle #(.OCC_CYCLES(OCC_CYCLES)) u_thr (
    .clk         (clk),
    .rst         (rst),
    .issue       (grant_any),
    .pipe_free   (pipe_free),
    .pipe_active (pipe_active)
  );

  wis_util_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .issue       (grant_any),
    .pipe_active (pipe_active),
    .cnt_cycles  (cnt_cycles),
    .cnt_issue   (cnt_issue),
    .cnt_busy    (cnt_pipe_busy)
  );

  assign inst_ready  = grant;
  assign issue_valid = grant_any;
  assign issue_warp  = grant_idx;
  assign issue_dst   = slot_instr[grant_idx].dst;
  assign issue_src0  = slot_instr[grant_idx].src0;
  assign issue_src1  = slot_instr[grant_idx].src1;

  // R9: only a slot that offers an instruction can issue
  assert_valid_only_R9: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> inst_valid[issue_warp]);

  generate
    if (OCC_CYCLES > 1) begin : g_gap_chk
      // R3: a two-pass warp leaves the following cycle without an issue
      assert_pipe_gap_R3: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !issue_valid);
    end
  endgenerate
endmodule

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;
  localparam int NW = 4;
  localparam int RW = 5;

  typedef struct {
    int    cyc;
    int    warp;
    int    dst;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NW-1:0]    inst_valid, inst_ready, v2, r2;
  logic [NW*RW-1:0] inst_dst, inst_src0, inst_src1, d2, a2, b2;
  logic             issue_valid, iv2;
  logic [1:0]       issue_warp, iw2;
  logic [RW-1:0]    issue_dst, issue_src0, issue_src1, id2, ia2, ib2;
  logic [31:0]      cnt_cycles, cnt_issue, cnt_pipe_busy, cc2, ci2, cb2;

  warp_issue_sched u_dut (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_dst(inst_dst), .inst_src0(inst_src0), .inst_src1(inst_src1),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_dst(issue_dst),
    .issue_src0(issue_src0), .issue_src1(issue_src1), .cnt_cycles(cnt_cycles),
    .cnt_issue(cnt_issue), .cnt_pipe_busy(cnt_pipe_busy));

  warp_issue_sched #(.DEP_LAT(16)) u_dut_lat16 (
    .clk(clk), .rst(rst), .inst_valid(v2), .inst_ready(r2),
    .inst_dst(d2), .inst_src0(a2), .inst_src1(b2),
    .issue_valid(iv2), .issue_warp(iw2), .issue_dst(id2),
    .issue_src0(ia2), .issue_src1(ib2), .cnt_cycles(cc2),
    .cnt_issue(ci2), .cnt_pipe_busy(cb2));

  logic [RW-1:0] pdst [NW][8];
  logic [RW-1:0] ps0  [NW][8];
  logic [RW-1:0] ps1  [NW][8];
  int plen [NW];
  int ptr  [NW];
  int ptr2 [NW];

  int   nchk = 0;
  int   nerr = 0;
  int   tcyc = 0;
  bit   running = 0;
  exp_t expq [$];
  exp_t e;
  int   lat_log [$];

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      inst_valid[w]          = ptr[w] < plen[w];
      inst_dst [w*RW +: RW]  = pdst[w][ptr[w] & 7];
      inst_src0[w*RW +: RW]  = ps0 [w][ptr[w] & 7];
      inst_src1[w*RW +: RW]  = ps1 [w][ptr[w] & 7];
      v2[w]                  = ptr2[w] < plen[w];
      d2[w*RW +: RW]         = pdst[w][ptr2[w] & 7];
      a2[w*RW +: RW]         = ps0 [w][ptr2[w] & 7];
      b2[w*RW +: RW]         = ps1 [w][ptr2[w] & 7];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int w = 0; w < NW; w++) begin
      plen[w] = 0; ptr[w] = 0; ptr2[w] = 0;
      for (int k = 0; k < 8; k++) begin
        pdst[w][k] = '0; ps0[w][k] = '0; ps1[w][k] = '0;
      end
    end
  endtask

  task automatic put(input int w, input int k, input int d, input int s0, input int s1);
    pdst[w][k] = RW'(d); ps0[w][k] = RW'(s0); ps1[w][k] = RW'(s1);
    if (plen[w] < k + 1) plen[w] = k + 1;
  endtask

  // r0=r1+r2 ; r4=r0+r3 ; r8=r0+r4
  task automatic load_chain(input int w);
    put(w, 0, 0, 1, 2);
    put(w, 1, 4, 0, 3);
    put(w, 2, 8, 0, 4);
  endtask

  task automatic expect_issue(input int cyc, input int warp, input int dst, input string req);
    exp_t x;
    x.cyc = cyc; x.warp = warp; x.dst = dst; x.req = req;
    expq.push_back(x);
  endtask

  task automatic do_reset();
    running = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    tcyc = 0;
  endtask

  // Driver: steps cycles, takes the offered instruction when the design accepts it.
  task automatic run(input int n);
    int took, took2;
    running = 1;
    tcyc = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      took  = issue_valid ? int'(issue_warp) : -1;
      took2 = iv2 ? int'(iw2) : -1;
      if (iv2) lat_log.push_back(tcyc);
      @(posedge clk);
      #1;
      if (took  >= 0) ptr[took]++;
      if (took2 >= 0) ptr2[took2]++;
      tcyc++;
    end
    running = 0;
  endtask

  // Monitor: pops the expected issue for every issue the design makes.
  always @(negedge clk) begin
    if (running && issue_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", "unexpected issue at cycle", tcyc, -1);
      end else begin
        e = expq.pop_front();
        check(tcyc == e.cyc, e.req, "issue cycle", tcyc, e.cyc);
        check(int'(issue_warp) == e.warp, e.req, "issue warp", issue_warp, e.warp);
        check(int'(issue_dst) == e.dst, "R2", "issue dst", issue_dst, e.dst);
        check(inst_ready == NW'(1 << issue_warp), "R12", "ready one-hot",
              inst_ready, 1 << issue_warp);
      end
    end
  end

  task automatic check_counts(input string req, input int cyc, input int iss, input int busy);
    check(cnt_cycles == 32'(cyc), req, "cnt_cycles", cnt_cycles, cyc);
    check(cnt_issue == 32'(iss), req, "cnt_issue", cnt_issue, iss);
    check(cnt_pipe_busy == 32'(busy), req, "cnt_pipe_busy", cnt_pipe_busy, busy);
    check(expq.size() == 0, req, "expected issues left over", expq.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clear_prog();
    // Reset state and R9 idle slots
    do_reset();
    check(cnt_cycles == 0 && cnt_issue == 0 && cnt_pipe_busy == 0, "R11",
          "counters after reset", cnt_cycles + cnt_issue + cnt_pipe_busy, 0);
    check(issue_valid == 1'b0, "R9", "issue with no valid slot", issue_valid, 0);
    run(5);
    check(inst_ready == '0, "R9", "ready with no valid slot", inst_ready, 0);
    check_counts("R9", 5, 0, 0);

    // R6: single warp chain, 25% issue, 50% pipe
    clear_prog();
    load_chain(0);
    do_reset();
    expect_issue(0, 0, 0, "R6");
    expect_issue(4, 0, 4, "R1");
    expect_issue(8, 0, 8, "R6");
    run(12);
    check_counts("R6", 12, 3, 6);

    // R7: two warps fill the gaps; R4 throttle, R5 no switch cost, R10 per-warp scoreboard
    clear_prog();
    load_chain(0);
    load_chain(1);
    do_reset();
    expect_issue(0, 0, 0, "R7");
    expect_issue(2, 1, 0, "R4");
    expect_issue(4, 0, 4, "R10");
    expect_issue(6, 1, 4, "R5");
    expect_issue(8, 0, 8, "R7");
    expect_issue(10, 1, 8, "R7");
    run(12);
    check_counts("R7", 12, 6, 12);

    // R8: four independent streams rotate; R3 every other cycle
    clear_prog();
    for (int w = 0; w < NW; w++) begin
      put(w, 0, 10 + 2*w, 1, 2);
      put(w, 1, 11 + 2*w, 1, 2);
    end
    do_reset();
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < NW; w++)
        expect_issue(8*k + 2*w, w, 10 + 2*w + k, (w == 0) ? "R3" : "R8");
    run(16);
    check_counts("R8", 16, 8, 16);

    // R11: reset during a dependency wait clears the scoreboard
    clear_prog();
    put(0, 0, 0, 1, 2);
    put(0, 1, 5, 0, 0);
    do_reset();
    expect_issue(0, 0, 0, "R11");
    run(1);
    do_reset();
    check(cnt_cycles == 0 && cnt_issue == 0 && cnt_pipe_busy == 0, "R11",
          "counters after mid-run reset", cnt_cycles + cnt_issue + cnt_pipe_busy, 0);
    expect_issue(0, 0, 5, "R11");
    run(3);
    check_counts("R11", 3, 1, 2);

    // R1 at latency 16 on the second instance, R6 again on the first
    clear_prog();
    load_chain(0);
    do_reset();
    lat_log.delete();
    expect_issue(0, 0, 0, "R6");
    expect_issue(4, 0, 4, "R1");
    expect_issue(8, 0, 8, "R1");
    run(40);
    check(lat_log.size() == 3, "R1", "lat16 issue count", lat_log.size(), 3);
    if (lat_log.size() == 3) begin
      check(lat_log[0] == 0,  "R1", "lat16 first issue",  lat_log[0], 0);
      check(lat_log[1] == 16, "R1", "lat16 second issue", lat_log[1], 16);
      check(lat_log[2] == 32, "R1", "lat16 third issue",  lat_log[2], 32);
    end
    check(ci2 == 32'd3, "R1", "lat16 cnt_issue", ci2, 3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule